// File: doc/BRIEF.md
# Weighted Round Queue Scheduler

This block chooses, every clock cycle, which one of several output queues that share a single port may send next. Each queue holds a service level from 0 to 8. The level is turned into an 8-bit participation pattern whose set bits are spread across eight scheduling rounds, so a higher level takes part in more rounds. The reserved level 9 places a queue in a strict-priority class. That class is made of the unbroken run of level-9 queues that begins at queue 0. Queues in the class always win over weighted queues, and the lowest index wins inside the class.

Software programs the levels through a one-cycle write strobe with a queue select. It may rewrite a level at any time, including while traffic flows. A level above 9 is flagged as a configuration error and served as if every round were enabled. The data path supplies one "has data" flag per queue. The block answers with a registered one-hot grant and a valid strobe. Packet storage and command buffering are left to the surrounding logic.

Top module: `wrs_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant`, `grant_vld` and `cfg_err` are zero. The round counter starts at round 0, and the weighted search starts at queue 0. All queues start at level 0.
- R2: Level L sets round participation as follows, with bit r meaning round r: 0→8'h00, 1→8'h01, 2→8'h11, 3→8'h49, 4→8'h55, 5→8'h57, 6→8'h77, 7→8'h7F, 8→8'hFF, 9→8'hFF.
- R3: A queue is in the strict class when its level is 9 and every lower-indexed queue is also in the class. When any queue in the class has data, the grant goes to the lowest-indexed one among them. The weighted round and pointer are then left unchanged.
- R4: A level-9 queue that is not part of the unbroken run from queue 0 is scheduled as a weighted queue with pattern 8'hFF.
- R5: When no strict queue has data, the grant goes to the lowest-indexed weighted queue that meets three conditions: its index is at or above the search start, its bit for the current round is set, and it has data. The search start then becomes that index plus one.
- R6: If no weighted queue qualifies at or above the search start, the round advances by one (mod 8). In the same cycle, the grant goes to the lowest-indexed weighted queue with data whose bit is set in the new round, and the search start becomes that index plus one.
- R7: If nothing qualifies, `grant_vld` is 0 and `grant` is zero. The round still advances by one, and the search start is held. Whenever `grant_vld` is 1, `grant` has exactly one bit set.
- R8: A write of a level above 9 raises `cfg_err` in the cycle after the write, and only then. That queue is then scheduled as weighted with pattern 8'hFF.
- R9: A level write is used by the grant decision made at the next clock edge after the write edge. Rewrites during traffic change service from that point on.
- R10: A queue at level 0 is never granted.
- R11: The grant and the valid strobe are registered. They reflect the `q_has_data` value and the state present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Level write strobe |
| cfg_qsel | input | QW | Queue selected by the write |
| cfg_level | input | 4 | Level written (0..8 weighted, 9 strict, above 9 error) |
| cfg_err | output | 1 | Pulses one cycle after a write of a level above 9 |
| q_has_data | input | NQ | Per-queue has-data flag |
| grant | output | NQ | One-hot grant |
| grant_vld | output | 1 | Grant valid strobe |

## Verification
The bench runs a mix of levels across all eight queues with every queue ready. This exposes the per-round pattern table and the ascending visit order within a round. A sparse ready pattern is used next, so that rounds are skipped and the round step with an immediate grant in the new round is exercised. A single ready queue follows, which isolates one participation pattern. The strict class is tried with all queues ready and with the class head idle, which separates lowest-index strict selection from weighted fallback. A broken level-9 run, an out-of-range level and a live rewrite then distinguish prefix detection, error flagging and the timing at which a write takes effect.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam int ROUNDS  = 8;
    localparam int RW      = 3;
    localparam int LVL_W   = 4;
    localparam logic [LVL_W-1:0] LVL_STRICT = 4'd9;

    // Participation pattern per service level; bits spread evenly over rounds.
    function automatic logic [ROUNDS-1:0] level_mask(input logic [LVL_W-1:0] lv);
        logic [ROUNDS-1:0] m;
        case (lv)
            4'd0:    m = 8'h00;
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wrs_cfg.sv
module wrs_cfg
    import wrs_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [QW-1:0]             sel,
    input  logic [LVL_W-1:0]          level,
    output logic [NQ-1:0][ROUNDS-1:0] mask,
    output logic [NQ-1:0]             strict,
    output logic                      err
);

    typedef struct packed {
        logic [NQ-1:0][LVL_W-1:0] lvl;
        logic                     err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    bad_lvl;

    assign bad_lvl = level > LVL_STRICT;

    always_comb begin
        st_d     = st_q;
        st_d.err = we && bad_lvl;
        if (we) begin
            st_d.lvl[sel] = bad_lvl ? 4'd8 : level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Strict class is the unbroken run of level-9 queues from queue 0.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            mask[i] = level_mask(st_q.lvl[i]);
            if (i == 0) begin
                strict[i] = st_q.lvl[i] == LVL_STRICT;
            end else begin
                strict[i] = strict[i-1] && (st_q.lvl[i] == LVL_STRICT);
            end
        end
    end

    assign err = st_q.err;

    p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && level > LVL_STRICT) |=> err);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && level > LVL_STRICT) |=> !err);

endmodule

// File: rtl/wrs_ffs.sv
module wrs_ffs #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/wrs_sched.sv
module wrs_sched
    import wrs_pkg::*;
#(
    parameter int NQ = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_qsel,
    input  logic [LVL_W-1:0] cfg_level,
    output logic             cfg_err,
    input  logic [NQ-1:0]    q_has_data,
    output logic [NQ-1:0]    grant,
    output logic             grant_vld
);

    localparam int FW = QW + 1;

    typedef struct packed {
        logic [NQ-1:0] grant;
        logic          vld;
        logic [RW-1:0] round;
        logic [FW-1:0] from;
    } sch_st_t;

    sch_st_t st_d, st_q;

    logic [NQ-1:0][ROUNDS-1:0] mask;
    logic [NQ-1:0]             strict;
    logic [NQ-1:0]             s_vec, c_vec, n_vec;
    logic                      s_found, c_found, n_found;
    logic [QW-1:0]             s_idx, c_idx, n_idx;
    logic [RW-1:0]             round_nx;

    wrs_cfg #(.NQ(NQ), .QW(QW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_qsel),
        .level  (cfg_level),
        .mask   (mask),
        .strict (strict),
        .err    (cfg_err)
    );

    assign round_nx = st_q.round + 3'd1;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            s_vec[i] = strict[i] && q_has_data[i];
            c_vec[i] = !strict[i] && q_has_data[i] && mask[i][st_q.round]
                       && (FW'(i) >= st_q.from);
            n_vec[i] = !strict[i] && q_has_data[i] && mask[i][round_nx];
        end
    end

    wrs_ffs #(.N(NQ), .W(QW)) u_ffs_strict (.vec(s_vec), .found(s_found), .idx(s_idx));
    wrs_ffs #(.N(NQ), .W(QW)) u_ffs_cur    (.vec(c_vec), .found(c_found), .idx(c_idx));
    wrs_ffs #(.N(NQ), .W(QW)) u_ffs_next   (.vec(n_vec), .found(n_found), .idx(n_idx));

    always_comb begin
        st_d       = st_q;
        st_d.grant = '0;
        st_d.vld   = 1'b0;
        if (s_found) begin
            st_d.grant[s_idx] = 1'b1;
            st_d.vld          = 1'b1;
        end else if (c_found) begin
            st_d.grant[c_idx] = 1'b1;
            st_d.vld          = 1'b1;
            st_d.from         = FW'(c_idx) + FW'(1);
        end else if (n_found) begin
            st_d.grant[n_idx] = 1'b1;
            st_d.vld          = 1'b1;
            st_d.round        = round_nx;
            st_d.from         = FW'(n_idx) + FW'(1);
        end else begin
            st_d.round        = round_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.grant;
    assign grant_vld = st_q.vld;

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $countones(grant) == 1);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> grant == '0);

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> st_q.from == $past(st_q.from));

    p_strict_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(strict & q_has_data)) |-> (grant_vld && ((grant & $past(strict)) != '0)));

    p_round_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.round == $past(st_q.round)) || (st_q.round == $past(st_q.round) + 3'd1));

endmodule

// File: tb/wrs_sched_test.sv
module wrs_sched_test;

    localparam int NQ = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_qsel = '0;
    logic [3:0]       cfg_level = '0;
    logic             cfg_err;
    logic [NQ-1:0]    q_has_data = '0;
    logic [NQ-1:0]    grant;
    logic             grant_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [NQ-1:0] g;
        logic          v;
        logic          e;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    int lvl_m[NQ];
    int round_m = 0;
    int from_m  = 0;

    always #4 clk = ~clk;

    wrs_sched #(.NQ(NQ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_qsel   (cfg_qsel),
        .cfg_level  (cfg_level),
        .cfg_err    (cfg_err),
        .q_has_data (q_has_data),
        .grant      (grant),
        .grant_vld  (grant_vld)
    );

    function automatic logic [7:0] pat(input int l);
        case (l)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h11;
            3: return 8'h49;
            4: return 8'h55;
            5: return 8'h57;
            6: return 8'h77;
            7: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // Driver: applies one cycle of stimulus, predicts the registered outcome.
    task automatic step(input logic [NQ-1:0] rdy, input bit we, input int sel,
                        input int lv, input string tag);
        exp_t e;
        bit   strict_m[NQ];
        bit   run;
        int   hit;
        int   r1;
        q_has_data = rdy;
        cfg_we     = we;
        cfg_qsel   = 3'(sel);
        cfg_level  = 4'(lv);
        run = 1;
        for (int i = 0; i < NQ; i++) begin
            run = run && (lvl_m[i] == 9);
            strict_m[i] = run;
        end
        e.g = '0; e.v = 0; e.tag = tag;
        e.e = we && (lv > 9);
        hit = -1;
        for (int i = 0; i < NQ; i++)
            if (hit < 0 && strict_m[i] && rdy[i]) hit = i;
        if (hit < 0) begin
            for (int i = from_m; i < NQ; i++)
                if (hit < 0 && !strict_m[i] && rdy[i] && pat(lvl_m[i])[round_m]) hit = i;
            if (hit >= 0) begin
                from_m = hit + 1;
            end else begin
                r1 = (round_m + 1) % 8;
                for (int i = 0; i < NQ; i++)
                    if (hit < 0 && !strict_m[i] && rdy[i] && pat(lvl_m[i])[r1]) hit = i;
                round_m = r1;
                if (hit >= 0) from_m = hit + 1;
            end
        end
        if (hit >= 0) begin
            e.g[hit] = 1'b1;
            e.v = 1'b1;
        end
        if (we) lvl_m[sel] = lv;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_n(input int n, input logic [NQ-1:0] rdy, input string tag);
        for (int k = 0; k < n; k++) step(rdy, 0, 0, 0, tag);
    endtask

    // Monitor: compares registered outputs shortly after each edge (R11).
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " grant"}, 32'(grant), 32'(e.g));
            check({e.tag, " grant_vld"}, 32'(grant_vld), 32'(e.v));
            check({e.tag, " cfg_err R8"}, 32'(cfg_err), 32'(e.e));
        end
    end

    initial begin
        for (int i = 0; i < NQ; i++) lvl_m[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 grant", 32'(grant), 32'h0);
        check("R1 grant_vld", 32'(grant_vld), 32'h0);
        check("R1 cfg_err", 32'(cfg_err), 32'h0);
        rst_n = 1'b1;
        // R10: all levels zero, nothing is granted
        run_n(4, 8'hFF, "R10");
        // Program a mix of levels with traffic idle (R7)
        step(8'h00, 1, 0, 1, "R7");
        step(8'h00, 1, 1, 2, "R7");
        step(8'h00, 1, 2, 8, "R7");
        step(8'h00, 1, 3, 0, "R7");
        step(8'h00, 1, 4, 4, "R7");
        step(8'h00, 1, 5, 5, "R7");
        step(8'h00, 1, 6, 3, "R7");
        step(8'h00, 1, 7, 7, "R7");
        run_n(40, 8'hFF, "R5");
        run_n(24, 8'b1010_0101, "R6");
        run_n(16, 8'b0000_0010, "R2");
        // Strict class of queues 0 and 1
        step(8'hFF, 1, 0, 9, "R3");
        step(8'hFF, 1, 1, 9, "R9");
        run_n(8, 8'hFF, "R3");
        run_n(6, 8'b1111_1110, "R3");
        run_n(6, 8'b1111_1100, "R3");
        run_n(3, 8'h00, "R7");
        // Broken strict run: queue 1 weighted, queue 3 level 9 is weighted
        step(8'h00, 1, 1, 1, "R4");
        step(8'h00, 1, 3, 9, "R4");
        run_n(16, 8'b0000_1010, "R4");
        // Out-of-range level
        step(8'b0010_0000, 1, 5, 12, "R8");
        run_n(10, 8'b0010_0000, "R8");
        // Live rewrite while traffic flows
        step(8'b0010_0000, 1, 5, 1, "R9");
        run_n(20, 8'b0010_0000, "R9");
        run_n(16, 8'hFF, "R5");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule